// File: doc/BRIEF.md
# Run-Mode Clock Source Switcher

This controller decides which oscillator clocks a device: the external primary oscillator, or the internal oscillator multiplexer. A two-bit mode field picks the run mode. A frequency field and an internal-source bit decide whether the internal multiplexer drives a real output. The controller enables the primary oscillator only when it may be needed. It moves the system clock between the two sources through a glitch-free gated multiplexer. It reports two flags: one says the primary clock is in use, the other says the internal output has settled.

The controller runs on a reference clock `clk`. The state machine has five states:

- `ST_WAIT_PRI`: running from internal, primary enabled and starting.
- `ST_TO_PRI`: handshake moving the clock to the primary.
- `ST_PRI`: running from the primary.
- `ST_TO_INT`: handshake moving the clock to the internal source.
- `ST_INT`: running from internal, primary disabled.

The transitions are:

- Reset → `ST_WAIT_PRI`.
- `ST_WAIT_PRI` → `ST_TO_PRI` when the primary reports ready and internal mode is not requested.
- `ST_WAIT_PRI` → `ST_INT` when internal mode is requested.
- `ST_TO_PRI` → `ST_PRI` once the gated multiplexer reports the primary gate open and the internal gate closed.
- `ST_PRI` → `ST_TO_INT` when internal mode is requested.
- `ST_TO_INT` → `ST_INT` once the multiplexer reports the internal gate open and the primary gate closed.
- `ST_INT` → `ST_WAIT_PRI` when internal mode is released.

Settling of the internal output is modelled by a counter of reference cycles. The counter runs whenever the internal output is enabled, whatever the mode. For that reason, an output that has already settled reports stable as soon as internal mode is entered.

Top module: `runclk_switch`

## Requirements
- R1: Internal run mode is requested when `mode_sel[1]` is 1. `mode_sel[0]` has no effect in any state.
- R2: When internal mode is requested from primary running, `pri_active` is 0 after the next `clk` edge. `pri_osc_en` falls only after the system clock is gated from `int_clk`. It stays 0 while internal mode is held.
- R3: `int_freq` takes the value of `freq_sel` at every `clk` edge. This includes edges during settling.
- R4: While `freq_sel` is 0 and `int_src_sel` is 0:
  - `int_out_en` is 0;
  - `int_stable` is 0;
  - in internal mode, `lf_run` is 1.
- R5: Once `int_out_en` becomes 1, `int_stable` reads 0 for the first SETTLE_CYC-1 edges and 1 from the SETTLE_CYC-th edge on. Changing `freq_sel` between non-zero values does not restart this count. Returning to a disabled output does restart it.
- R6: If the internal output has already settled, `int_stable` is 1 from the first edge after internal mode is requested, with no new delay.
- R7: After internal mode is released, the system clock stays on `int_clk` and `pri_active` stays 0 for as long as `pri_ready` is 0. Only after `pri_ready` is 1 does the clock move to `pri_clk`.
- R8: When the move to the primary completes:
  - `pri_active` becomes 1;
  - `int_stable` becomes 0;
  - `sys_clk` follows `pri_clk`.
  `pri_active` and `int_stable` are never both 1.
- R9: `lf_run` is 1 whenever `wdt_en` or `mon_en` is 1. In primary running with both at 0, it is 0.
- R10: The two clock gates are never open at once. Each gate changes only on a falling edge of its own clock, after a two-stage synchronised handshake.
- R11: After reset:
  - `pri_active` is 0;
  - `pri_osc_en` is 1;
  - `int_stable` is 0;
  - `lf_run` is 1;
  - `sys_clk` follows `int_clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock for the controller |
| rst_n | input | 1 | Active-low asynchronous reset |
| pri_clk | input | 1 | Primary oscillator clock |
| int_clk | input | 1 | Internal oscillator multiplexer clock |
| mode_sel | input | 2 | Run-mode select; bit 1 requests internal mode |
| freq_sel | input | FREQ_W | Internal frequency select; 0 with `int_src_sel` 0 disables the internal output |
| int_src_sel | input | 1 | Forces the internal output on |
| pri_ready | input | 1 | Primary oscillator reports it is ready |
| wdt_en | input | 1 | Watchdog needs the low-frequency source |
| mon_en | input | 1 | Clock monitor needs the low-frequency source |
| sys_clk | output | 1 | Glitch-free system clock |
| pri_osc_en | output | 1 | Enable for the primary oscillator |
| int_out_en | output | 1 | Internal multiplexer output enabled |
| int_freq | output | FREQ_W | Frequency code applied to the internal source |
| lf_run | output | 1 | Keep the low-frequency internal source running |
| pri_active | output | 1 | System clock comes from the primary |
| int_stable | output | 1 | Internal output has settled (not set in primary running) |

## Verification
The bench builds the block with SETTLE_CYC = 12, FREQ_W = 3 and two synchroniser stages. The short settling window makes it practical to check each edge around the threshold. It also leaves room to change the frequency code inside the window, and to clear and restart it. The primary, internal and reference clocks have unrelated periods. Because of this, every switch is exercised with the handshake stepping through both foreign clock domains, and `sys_clk` is compared with the selected source at points away from any clock edge.

// File: rtl/runclk_pkg.sv
package runclk_pkg;

    typedef enum logic [2:0] {
        ST_WAIT_PRI = 3'd0,
        ST_TO_PRI   = 3'd1,
        ST_PRI      = 3'd2,
        ST_TO_INT   = 3'd3,
        ST_INT      = 3'd4
    } run_state_t;

endpackage

// File: rtl/runclk_settle.sv
module runclk_settle #(
    parameter int FREQ_W     = 3,
    parameter int SETTLE_CYC = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FREQ_W-1:0] freq_sel,
    input  logic              int_src_sel,
    output logic              out_en,
    output logic              settled
);
    localparam int CNT_W = $clog2(SETTLE_CYC + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_CYC - 1);

    logic [CNT_W-1:0] cnt;

    assign out_en = (freq_sel != '0) || int_src_sel;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            settled <= 1'b0;
        end else if (!out_en) begin
            cnt     <= '0;
            settled <= 1'b0;
        end else begin
            if (!settled) begin
                cnt <= cnt + 1'b1;
            end
            settled <= settled || (cnt == LAST);
        end
    end

    // R5: stability can only appear while the output is enabled
    assert_settle_needs_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(settled) |-> $past(out_en));

    // R4: a disabled output never reports stable on the following edge
    assert_disabled_not_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |=> !settled);

endmodule

// File: rtl/runclk_gfmux.sv
module runclk_gfmux #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pri_clk,
    input  logic int_clk,
    input  logic want_pri,
    output logic sys_clk,
    output logic on_pri,
    output logic on_int
);
    localparam int MSB = SYNC_STAGES - 1;

    logic [MSB:0] p_sync, i_sync, p_back, i_back;
    logic         gate_pri, gate_int;

    // primary-side request: opens only after the internal gate is closed
    always_ff @(posedge pri_clk or negedge rst_n) begin
        if (!rst_n) p_sync <= '0;
        else        p_sync <= {p_sync[MSB-1:0], want_pri & ~gate_int};
    end

    always_ff @(negedge pri_clk or negedge rst_n) begin
        if (!rst_n) gate_pri <= 1'b0;
        else        gate_pri <= p_sync[MSB];
    end

    // internal-side request: opens only after the primary gate is closed
    always_ff @(posedge int_clk or negedge rst_n) begin
        if (!rst_n) i_sync <= '1;
        else        i_sync <= {i_sync[MSB-1:0], ~want_pri & ~gate_pri};
    end

    always_ff @(negedge int_clk or negedge rst_n) begin
        if (!rst_n) gate_int <= 1'b1;
        else        gate_int <= i_sync[MSB];
    end

    // gate status brought back to the controller clock
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_back <= '0;
            i_back <= '1;
        end else begin
            p_back <= {p_back[MSB-1:0], gate_pri};
            i_back <= {i_back[MSB-1:0], gate_int};
        end
    end

    assign on_pri  = p_back[MSB];
    assign on_int  = i_back[MSB];
    assign sys_clk = (pri_clk & gate_pri) | (int_clk & gate_int);

    // R10: the two gates are never open together
    assert_gates_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_pri && gate_int));

endmodule

// File: rtl/runclk_fsm.sv
module runclk_fsm
    import runclk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mode_int,
    input  logic pri_ready,
    input  logic on_pri,
    input  logic on_int,
    output logic want_pri,
    output logic pri_osc_en,
    output logic pri_active,
    output logic int_ctx
);
    run_state_t state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_WAIT_PRI: begin
                if (mode_int)       state_nx = ST_INT;
                else if (pri_ready) state_nx = ST_TO_PRI;
            end
            ST_TO_PRI: if (on_pri && !on_int) state_nx = ST_PRI;
            ST_PRI:    if (mode_int)          state_nx = ST_TO_INT;
            ST_TO_INT: if (on_int && !on_pri) state_nx = ST_INT;
            ST_INT:    if (!mode_int)         state_nx = ST_WAIT_PRI;
            default:                          state_nx = ST_WAIT_PRI;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_WAIT_PRI;
        else        state <= state_nx;
    end

    always_comb begin
        want_pri   = 1'b0;
        pri_osc_en = 1'b1;
        pri_active = 1'b0;
        int_ctx    = 1'b1;
        unique case (state)
            ST_WAIT_PRI: ;
            ST_TO_PRI:   want_pri = 1'b1;
            ST_PRI: begin
                want_pri   = 1'b1;
                pri_active = 1'b1;
                int_ctx    = 1'b0;
            end
            ST_TO_INT:   ;
            ST_INT:      pri_osc_en = 1'b0;
            default:     ;
        endcase
    end

    // R8: primary reported active only after the gate handshake confirmed it
    assert_active_after_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pri_active) |-> $past(on_pri));

    // R7: the move toward the primary starts only with the primary ready
    assert_ready_before_switch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(want_pri) |-> $past(pri_ready));

    // R2: primary shut down only once the internal gate is confirmed open
    assert_pri_off_on_int_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pri_osc_en) |-> $past(on_int));

endmodule

// File: rtl/runclk_switch.sv
module runclk_switch #(
    parameter int FREQ_W      = 3,
    parameter int SETTLE_CYC  = 256,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pri_clk,
    input  logic              int_clk,
    input  logic [1:0]        mode_sel,
    input  logic [FREQ_W-1:0] freq_sel,
    input  logic              int_src_sel,
    input  logic              pri_ready,
    input  logic              wdt_en,
    input  logic              mon_en,
    output logic              sys_clk,
    output logic              pri_osc_en,
    output logic              int_out_en,
    output logic [FREQ_W-1:0] int_freq,
    output logic              lf_run,
    output logic              pri_active,
    output logic              int_stable
);
    logic want_pri, on_pri, on_int, int_ctx, settled;
    logic unused_mode_lo;

    assign unused_mode_lo = mode_sel[0];

    runclk_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_int   (mode_sel[1]),
        .pri_ready  (pri_ready),
        .on_pri     (on_pri),
        .on_int     (on_int),
        .want_pri   (want_pri),
        .pri_osc_en (pri_osc_en),
        .pri_active (pri_active),
        .int_ctx    (int_ctx)
    );

    runclk_settle #(.FREQ_W(FREQ_W), .SETTLE_CYC(SETTLE_CYC)) u_settle (
        .clk         (clk),
        .rst_n       (rst_n),
        .freq_sel    (freq_sel),
        .int_src_sel (int_src_sel),
        .out_en      (int_out_en),
        .settled     (settled)
    );

    runclk_gfmux #(.SYNC_STAGES(SYNC_STAGES)) u_mux (
        .clk      (clk),
        .rst_n    (rst_n),
        .pri_clk  (pri_clk),
        .int_clk  (int_clk),
        .want_pri (want_pri),
        .sys_clk  (sys_clk),
        .on_pri   (on_pri),
        .on_int   (on_int)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) int_freq <= '0;
        else        int_freq <= freq_sel;
    end

    assign int_stable = settled & int_ctx;
    assign lf_run     = wdt_en | mon_en | (int_ctx & ~int_out_en);

    // R8: the two status flags are mutually exclusive
    assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(pri_active && int_stable));

endmodule

// File: tb/runclk_switch_bench.sv
`timescale 1ns/100ps
module runclk_switch_bench;
    localparam int FW = 3;
    localparam int N  = 12;

    logic clk = 0, pri_clk = 0, int_clk = 0, rst_n = 0;
    logic [1:0] mode_sel = 2'b00;
    logic [FW-1:0] freq_sel = '0;
    logic int_src_sel = 0, pri_ready = 0, wdt_en = 0, mon_en = 0;
    logic sys_clk, pri_osc_en, int_out_en, lf_run, pri_active, int_stable;
    logic [FW-1:0] int_freq;
    int checks = 0, fails = 0;

    runclk_switch #(.FREQ_W(FW), .SETTLE_CYC(N), .SYNC_STAGES(2)) u_runclk_switch (
        .clk(clk), .rst_n(rst_n), .pri_clk(pri_clk), .int_clk(int_clk),
        .mode_sel(mode_sel), .freq_sel(freq_sel), .int_src_sel(int_src_sel),
        .pri_ready(pri_ready), .wdt_en(wdt_en), .mon_en(mon_en),
        .sys_clk(sys_clk), .pri_osc_en(pri_osc_en), .int_out_en(int_out_en),
        .int_freq(int_freq), .lf_run(lf_run), .pri_active(pri_active),
        .int_stable(int_stable));

    always #4 clk = ~clk;
    initial begin #1;   forever #10 pri_clk = ~pri_clk; end
    initial begin #0.5; forever #7  int_clk = ~int_clk; end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // compare sys_clk with the chosen source at several points
    task automatic chk_follow(input string tag, input bit on_primary);
        int bad = 0;
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            if (sys_clk !== (on_primary ? pri_clk : int_clk)) bad++;
        end
        chk(tag, bad, 0);
    endtask

    task automatic wait_pri(input logic want);
        for (int i = 0; i < 200; i++) begin
            if (pri_active === want) break;
            @(negedge clk);
        end
    endtask

    task automatic wait_osc_off();
        for (int i = 0; i < 200; i++) begin
            if (pri_osc_en === 1'b0) break;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        chk("R11 pri_active", pri_active, 0);
        chk("R11 pri_osc_en", pri_osc_en, 1);
        chk("R11 int_stable", int_stable, 0);
        chk("R11 lf_run", lf_run, 1);
        chk_follow("R11 sys_clk on int", 0);
    endtask

    task automatic t_hold_until_ready();
        cyc(60);
        chk("R7 no switch w/o ready", pri_active, 0);
        chk("R7 pri_osc_en on", pri_osc_en, 1);
        chk_follow("R7 sys_clk stays int", 0);
        pri_ready = 1;
        wait_pri(1);
        chk("R7 switched after ready", pri_active, 1);
        chk("R8 stable clear on pri", int_stable, 0);
        chk_follow("R8 sys_clk on pri", 1);
    endtask

    task automatic t_low_bit_ignored();
        mode_sel = 2'b01;
        cyc(50);
        chk("R1 low bit ignored", pri_active, 1);
        chk_follow("R1 still pri clock", 1);
        mode_sel = 2'b00;
    endtask

    task automatic t_to_int_disabled();
        freq_sel = '0; int_src_sel = 0;
        mode_sel = 2'b10;
        cyc(1);
        chk("R2 pri_active clears", pri_active, 0);
        wait_osc_off();
        chk("R2 pri_osc_en off", pri_osc_en, 0);
        chk("R4 out_en 0", int_out_en, 0);
        chk("R4 stable 0", int_stable, 0);
        chk("R4 lf_run 1", lf_run, 1);
        chk_follow("R2 sys_clk on int", 0);
        mode_sel = 2'b11;
        cyc(30);
        chk("R1 mode 11 same as 10", pri_osc_en, 0);
        chk("R1 mode 11 pri inactive", pri_active, 0);
    endtask

    task automatic t_settle();
        freq_sel = 3'd3;
        cyc(1);
        chk("R3 freq follows", int_freq, 3);
        chk("R5 out_en on", int_out_en, 1);
        cyc(N - 2);
        chk("R5 not yet stable", int_stable, 0);
        cyc(1);
        chk("R5 stable at N", int_stable, 1);
    endtask

    task automatic t_settle_change();
        freq_sel = '0;
        cyc(1);
        chk("R4 stable drops", int_stable, 0);
        freq_sel = 3'd2;
        cyc(4);
        freq_sel = 3'd5;
        cyc(1);
        chk("R3 freq change mid-settle", int_freq, 5);
        cyc(N - 6);
        chk("R5 no restart, not yet", int_stable, 0);
        cyc(1);
        chk("R5 no restart, stable at N", int_stable, 1);
    endtask

    task automatic t_src_restart();
        freq_sel = '0;
        cyc(3);
        int_src_sel = 1;
        cyc(N - 1);
        chk("R5 restart via src, not yet", int_stable, 0);
        cyc(1);
        chk("R5 restart via src, stable", int_stable, 1);
        int_src_sel = 0;
    endtask

    task automatic t_already_stable();
        freq_sel = 3'd4;
        cyc(N + 2);
        mode_sel = 2'b00;
        wait_pri(1);
        chk("R8 pri active again", pri_active, 1);
        chk("R8 stable cleared", int_stable, 0);
        mode_sel = 2'b10;
        cyc(1);
        chk("R6 stable immediate", int_stable, 1);
        chk("R2 pri_active off", pri_active, 0);
        wait_osc_off();
        chk("R6 still stable", int_stable, 1);
    endtask

    task automatic t_lf();
        freq_sel = '0;
        mode_sel = 2'b00;
        wait_pri(1);
        chk("R9 lf off in pri", lf_run, 0);
        wdt_en = 1; cyc(1);
        chk("R9 lf on wdt", lf_run, 1);
        wdt_en = 0; mon_en = 1; cyc(1);
        chk("R9 lf on mon", lf_run, 1);
        mon_en = 0; cyc(1);
        chk("R9 lf off again", lf_run, 0);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        cyc(5);
        rst_n = 1;
        cyc(2);
        t_reset();
        t_hold_until_ready();
        t_low_bit_ignored();
        t_to_int_disabled();
        t_settle();
        t_settle_change();
        t_src_restart();
        t_already_stable();
        t_lf();
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule